// File: doc/BRIEF.md
# Translation Miss Assist Register Unit

This unit helps a software-managed TLB reload. When a data or instruction translation misses, the unit captures the missing effective address. It looks up the segment ID for that address and builds a compare word in the format of a page table entry's first word. It also forms the physical addresses of the two page table groups (primary and secondary) that the miss handler has to search. The handler reads these values through a small register port and does not rebuild them in code.

The unit has one compare register for each side (data and instruction). Each side also holds a private copy of the address and segment ID from its latest miss. An acknowledge input chooses which side feeds the two hash address outputs. The hash outputs are computed from the chosen side's captured values and from the current page table origin and mask inputs. The segment register file lives outside the unit. The unit drives a 4-bit index, and the file answers with the 24-bit segment ID in the same cycle.

Top module: `tlbm_assist_top`

## Requirements
- R1: Bit numbering is big-endian, so bit 0 is vector bit 31. A compare word has four fields. The valid flag is bit 0 (vector 31). The segment ID is bits 1–24 (vector 30:7). Bit 25 (vector 6) always reads 0. The abbreviated page index is bits 26–31 (vector 5:0). After reset, both compare registers are zero and the hash source is the data side.
- R2: A miss strobe updates the compare register of its own side on the next clock edge, with the valid flag set. The compare register of the other side is unchanged, unless software writes that register in the same cycle.
- R3: The segment index output equals effective address bits 0–3 (vector 31:28). The 24-bit segment ID returned on that index in the miss cycle is stored in the compare word.
- R4: The abbreviated page index field takes effective address bits 4–9 (vector 27:22).
- R5: Software register addresses are 0 for the data compare register, 1 for the instruction compare register, 2 for the primary hash and 3 for the secondary hash. A write to address 0 or 1 loads the word with bit 25 forced to 0. A miss on the same side in the same cycle takes priority over the write.
- R6: In both hash addresses, bits 0–6 (vector 31:25) equal table origin bits 0–6 (origin input vector 15:9).
- R7: The primary hash H is 19 bits. It is the low 19 bits of the selected side's captured segment ID XORed with the zero-extended 16-bit page index, which is effective address bits 4–19 (vector 27:12). Address bits 7–15 (vector 24:16) are (H[18:10] AND mask) OR origin bits 7–15 (origin vector 8:0). Address bits 16–25 (vector 15:6) are H[9:0]. Bits 26–31 (vector 5:0) are zero.
- R8: The secondary hash address is built in the same way from the ones-complement of H.
- R9: When the acknowledge strobe is active, its data/instruction flag (1 = instruction) selects the hash source from the next cycle on. The selection holds until the next acknowledge. A miss does not change the selection.
- R10: Software writes to addresses 2 and 3 have no effect. The read port returns, without delay, the value at the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | Miss strobe |
| miss_is_instr | input | 1 | Miss side: 1 = instruction, 0 = data |
| miss_ea | input | 32 | Missing effective address |
| seg_idx_o | output | 4 | Segment register index (EA bits 0–3) |
| seg_id_i | input | 24 | Segment ID returned for seg_idx_o |
| tbl_origin_i | input | 16 | Page table origin, bits 0–15 of the address |
| tbl_mask_i | input | 9 | Page table hash mask |
| ack_vld | input | 1 | Miss acknowledge strobe |
| ack_is_instr | input | 1 | Acknowledged side: 1 = instruction |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | 2 | Software register address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data |
| cmp_data_o | output | 32 | Data compare register |
| cmp_instr_o | output | 32 | Instruction compare register |
| hash_pri_o | output | 32 | Primary page table group address |
| hash_sec_o | output | 32 | Secondary page table group address |

## Verification
The assertions assume that, whenever the miss strobe is high, seg_id_i already holds the entry addressed by seg_idx_o in that same cycle. They also assume that all inputs are two-state after reset. The bench meets both assumptions. It answers the segment index from a combinational lookup into its own 16-entry array, and it drives every input at the falling clock edge from fixed-seed random two-state values. Random stimulus may make a miss, a software write and an acknowledge coincide on the same side, so the priority rules are exercised under load as well as in the directed cases.

// File: rtl/tlbm_pkg.sv
`timescale 1ns/1ps
package tlbm_pkg;
    localparam int WORD_W    = 32;
    localparam int SID_W     = 24;
    localparam int APIX_W    = 6;
    localparam int PIDX_W    = 16;
    localparam int HASH_W    = 19;
    localparam int SEGIX_W   = 4;
    localparam int ORG_W     = 16;
    localparam int MASK_W    = 9;
    localparam int LOW_W     = HASH_W - MASK_W;
    localparam int ORG_HI_W  = ORG_W - MASK_W;
    localparam int RSVD_BIT  = APIX_W;
    localparam int N_SIDES   = 2;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [SID_W-1:0]   sid_t;
    typedef logic [HASH_W-1:0]  hash_t;

    function automatic logic [SEGIX_W-1:0] ea_seg(input word_t ea);
        return ea[WORD_W-1 -: SEGIX_W];
    endfunction

    function automatic logic [APIX_W-1:0] ea_apix(input word_t ea);
        return ea[WORD_W-1-SEGIX_W -: APIX_W];
    endfunction

    function automatic logic [PIDX_W-1:0] ea_pidx(input word_t ea);
        return ea[WORD_W-1-SEGIX_W -: PIDX_W];
    endfunction

    function automatic word_t make_cmp(input logic v, input sid_t sid,
                                       input logic [APIX_W-1:0] ax);
        return {v, sid, 1'b0, ax};
    endfunction
endpackage

// File: rtl/tlbm_side.sv
`timescale 1ns/1ps
module tlbm_side
    import tlbm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  miss_hit,
    input  word_t miss_ea,
    input  sid_t  miss_sid,
    input  logic  sw_we,
    input  word_t sw_wdata,
    output word_t cmp_o,
    output word_t ea_o,
    output sid_t  sid_o
);
    typedef struct packed {
        word_t cmp;
        word_t ea;
        sid_t  sid;
    } side_st_t;

    side_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_we) begin
            st_d.cmp = sw_wdata;
            st_d.cmp[RSVD_BIT] = 1'b0;
        end
        if (miss_hit) begin
            st_d.cmp = make_cmp(1'b1, miss_sid, ea_apix(miss_ea));
            st_d.ea  = miss_ea;
            st_d.sid = miss_sid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o = st_q.cmp;
    assign ea_o  = st_q.ea;
    assign sid_o = st_q.sid;

    p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_hit |=> cmp_o[WORD_W-1]);
    p_sid_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_hit |=> cmp_o[WORD_W-2 -: SID_W] == $past(miss_sid));
    p_apix_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_hit |=> cmp_o[APIX_W-1:0] == $past(miss_ea[27:22]));
    p_sw_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !miss_hit) |=> cmp_o == ($past(sw_wdata) & ~(32'h1 << RSVD_BIT)));
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_o[RSVD_BIT]);
endmodule

// File: rtl/tlbm_hash.sv
`timescale 1ns/1ps
module tlbm_hash
    import tlbm_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
)(
    input  sid_t              sid,
    input  word_t             ea,
    input  logic [ORG_W-1:0]  origin,
    input  logic [MASK_W-1:0] mask,
    output word_t             addr
);
    hash_t h_base;
    hash_t h_sel;

    assign h_base = sid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, ea_pidx(ea)};

    generate
        if (SECONDARY) begin : g_sec
            assign h_sel = ~h_base;
        end else begin : g_pri
            assign h_sel = h_base;
        end
    endgenerate

    assign addr = {origin[ORG_W-1 -: ORG_HI_W],
                   (h_sel[HASH_W-1 -: MASK_W] & mask) | origin[MASK_W-1:0],
                   h_sel[LOW_W-1:0],
                   {APIX_W{1'b0}}};
endmodule

// File: rtl/tlbm_assist_top.sv
`timescale 1ns/1ps
module tlbm_assist_top
    import tlbm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        miss_vld,
    input  logic        miss_is_instr,
    input  logic [31:0] miss_ea,
    output logic [3:0]  seg_idx_o,
    input  logic [23:0] seg_id_i,
    input  logic [15:0] tbl_origin_i,
    input  logic [8:0]  tbl_mask_i,
    input  logic        ack_vld,
    input  logic        ack_is_instr,
    input  logic        sw_we,
    input  logic [1:0]  sw_addr,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata,
    output logic [31:0] cmp_data_o,
    output logic [31:0] cmp_instr_o,
    output logic [31:0] hash_pri_o,
    output logic [31:0] hash_sec_o
);
    typedef struct packed {
        logic sel_instr;
    } top_st_t;

    top_st_t st_d, st_q;

    word_t [N_SIDES-1:0] cmp_w;
    word_t [N_SIDES-1:0] ea_w;
    sid_t  [N_SIDES-1:0] sid_w;
    word_t [1:0]         hash_w;

    assign seg_idx_o = ea_seg(miss_ea);

    generate
        for (genvar s = 0; s < N_SIDES; s++) begin : g_side
            logic hit_s;
            logic we_s;
            assign hit_s = miss_vld && (miss_is_instr == s[0]);
            assign we_s  = sw_we && (sw_addr == 2'(s));
            tlbm_side u_side (
                .clk      (clk),
                .rst_n    (rst_n),
                .miss_hit (hit_s),
                .miss_ea  (miss_ea),
                .miss_sid (seg_id_i),
                .sw_we    (we_s),
                .sw_wdata (sw_wdata),
                .cmp_o    (cmp_w[s]),
                .ea_o     (ea_w[s]),
                .sid_o    (sid_w[s])
            );
        end
        for (genvar h = 0; h < 2; h++) begin : g_hash
            tlbm_hash #(.SECONDARY(h == 1)) u_hash (
                .sid    (sid_w[st_q.sel_instr]),
                .ea     (ea_w[st_q.sel_instr]),
                .origin (tbl_origin_i),
                .mask   (tbl_mask_i),
                .addr   (hash_w[h])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (ack_vld) st_d.sel_instr = ack_is_instr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_data_o  = cmp_w[0];
    assign cmp_instr_o = cmp_w[1];
    assign hash_pri_o  = hash_w[0];
    assign hash_sec_o  = hash_w[1];

    always_comb begin
        case (sw_addr)
            2'd0:    sw_rdata = cmp_w[0];
            2'd1:    sw_rdata = cmp_w[1];
            2'd2:    sw_rdata = hash_w[0];
            default: sw_rdata = hash_w[1];
        endcase
    end

    p_other_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_vld && !miss_is_instr && !(sw_we && sw_addr == 2'd1)) |=> $stable(cmp_instr_o));
    p_origin_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hash_pri_o[31:25] == tbl_origin_i[15:9] && hash_sec_o[31:25] == tbl_origin_i[15:9]);
    p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hash_pri_o[5:0] == 6'd0 && hash_sec_o[5:0] == 6'd0);
    p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hash_pri_o[15:6] == ~hash_sec_o[15:6]);
    p_ack_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |=> st_q.sel_instr == $past(ack_is_instr));
    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_vld |=> $stable(st_q.sel_instr));
endmodule

// File: tb/sim_tlbm_assist_top.sv
`timescale 1ns/1ps
module sim_tlbm_assist_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_vld, miss_is_instr;
    logic [31:0] miss_ea;
    logic [3:0]  seg_idx;
    logic [23:0] seg_id;
    logic [15:0] tbl_origin;
    logic [8:0]  tbl_mask;
    logic        ack_vld, ack_is_instr;
    logic        sw_we;
    logic [1:0]  sw_addr;
    logic [31:0] sw_wdata, sw_rdata;
    logic [31:0] cmp_data, cmp_instr, hash_pri, hash_sec;

    logic [23:0] seg_mem [16];
    logic [31:0] m_cmp [2];
    logic [31:0] m_ea  [2];
    logic [23:0] m_sid [2];
    logic        m_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always_comb seg_id = seg_mem[seg_idx];

    tlbm_assist_top u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_vld(miss_vld), .miss_is_instr(miss_is_instr), .miss_ea(miss_ea),
        .seg_idx_o(seg_idx), .seg_id_i(seg_id),
        .tbl_origin_i(tbl_origin), .tbl_mask_i(tbl_mask),
        .ack_vld(ack_vld), .ack_is_instr(ack_is_instr),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .cmp_data_o(cmp_data), .cmp_instr_o(cmp_instr),
        .hash_pri_o(hash_pri), .hash_sec_o(hash_sec)
    );

    function automatic logic [31:0] exp_hash(input logic [23:0] sid, input logic [31:0] ea,
                                             input logic [15:0] org, input logic [8:0] msk,
                                             input bit sec);
        logic [18:0] h;
        h = sid[18:0] ^ {3'b000, ea[27:12]};
        if (sec) h = ~h;
        return {org[15:9], (h[18:10] & msk) | org[8:0], h[9:0], 6'b000000};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        miss_vld = 1'b0; ack_vld = 1'b0; sw_we = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) begin
            if (sw_we && sw_addr < 2'd2) m_cmp[sw_addr[0]] = sw_wdata & ~32'h40;
            if (miss_vld) begin
                m_cmp[miss_is_instr] = {1'b1, seg_mem[miss_ea[31:28]], 1'b0, miss_ea[27:22]};
                m_ea[miss_is_instr]  = miss_ea;
                m_sid[miss_is_instr] = seg_mem[miss_ea[31:28]];
            end
            if (ack_vld) m_sel = ack_is_instr;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_all(input string tag);
        logic [31:0] ep, es;
        ep = exp_hash(m_sid[m_sel], m_ea[m_sel], tbl_origin, tbl_mask, 1'b0);
        es = exp_hash(m_sid[m_sel], m_ea[m_sel], tbl_origin, tbl_mask, 1'b1);
        check({tag, " R1 R2 cmp_data"}, cmp_data, m_cmp[0]);
        check({tag, " R1 R2 cmp_instr"}, cmp_instr, m_cmp[1]);
        check({tag, " R6 R7 R9 hash_pri"}, hash_pri, ep);
        check({tag, " R6 R8 R9 hash_sec"}, hash_sec, es);
        for (int a = 0; a < 4; a++) begin
            sw_addr = 2'(a);
            #0.1;
            check({tag, " R10 readback"}, sw_rdata,
                  (a == 0) ? m_cmp[0] : (a == 1) ? m_cmp[1] : (a == 2) ? ep : es);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) seg_mem[i] = 24'($urandom);
        for (int s = 0; s < 2; s++) begin
            m_cmp[s] = '0; m_ea[s] = '0; m_sid[s] = '0;
        end
        m_sel = 1'b0;
        rst_n = 1'b0;
        idle_inputs();
        miss_is_instr = 1'b0; miss_ea = '0; ack_is_instr = 1'b0;
        sw_addr = '0; sw_wdata = '0;
        tbl_origin = 16'hA5C3; tbl_mask = 9'h1FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R3 R4: data miss, segment selected by EA bits 0-3
        seg_mem[4'h7] = 24'hABCDEF;
        miss_vld = 1'b1; miss_is_instr = 1'b0; miss_ea = 32'h7F3A_5C00;
        #0.1;
        check("R3 seg index", {28'd0, seg_idx}, 32'h7);
        step();
        check("R3 R4 data cmp word", cmp_data, {1'b1, 24'hABCDEF, 1'b0, 6'b111100});
        check_all("R2 data miss");

        // R2: instruction miss leaves data side alone; hash still on data side
        miss_vld = 1'b1; miss_is_instr = 1'b1; miss_ea = 32'h2123_4567;
        step();
        check_all("R2 R9 instr miss no ack");

        // R9: acknowledge instruction side
        ack_vld = 1'b1; ack_is_instr = 1'b1;
        step();
        check_all("R9 ack instr");
        check("R9 hash from instr", hash_pri,
              exp_hash(seg_mem[2], 32'h2123_4567, tbl_origin, tbl_mask, 1'b0));

        // R7: mask zero keeps only origin in bits 7-15
        tbl_mask = 9'h000; tbl_origin = 16'h0000;
        #0.1;
        check("R7 mask zero", hash_pri[24:16], 32'h0);
        check_all("R7 R8 mask zero");
        tbl_mask = 9'h0F0; tbl_origin = 16'hFE01;
        #0.1;
        check_all("R6 R7 partial mask");

        // R5: software write clears bit 25
        sw_we = 1'b1; sw_addr = 2'd0; sw_wdata = 32'hFFFF_FFFF;
        step();
        check("R5 write clears rsvd", cmp_data, 32'hFFFF_FFBF);
        check_all("R5 sw write");

        // R5: miss beats same-cycle write on same side
        sw_we = 1'b1; sw_addr = 2'd1; sw_wdata = 32'h1234_5678;
        miss_vld = 1'b1; miss_is_instr = 1'b1; miss_ea = 32'hC000_0000;
        step();
        check("R5 miss priority", cmp_instr, {1'b1, seg_mem[12], 7'd0});
        check_all("R5 collide");

        // R10: writes to hash addresses ignored
        sw_we = 1'b1; sw_addr = 2'd2; sw_wdata = 32'hDEAD_BEEF;
        step();
        check_all("R10 write pri ignored");
        sw_we = 1'b1; sw_addr = 2'd3; sw_wdata = 32'h0BAD_F00D;
        step();
        check_all("R10 write sec ignored");

        // R9: ack back to data side
        ack_vld = 1'b1; ack_is_instr = 1'b0;
        step();
        check_all("R9 ack data");

        // random mix
        for (int n = 0; n < 400; n++) begin
            miss_vld      = ($urandom % 3) == 0;
            miss_is_instr = 1'($urandom);
            miss_ea       = $urandom;
            ack_vld       = ($urandom % 4) == 0;
            ack_is_instr  = 1'($urandom);
            sw_we         = ($urandom % 3) == 0;
            sw_addr       = 2'($urandom);
            sw_wdata      = $urandom;
            if (($urandom % 16) == 0) begin
                tbl_origin = 16'($urandom);
                tbl_mask   = 9'($urandom);
            end
            step();
            check_all("RND");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule